// File: doc/BRIEF.md
# Decode-Stage Latency Interlock

This block sits in the decode stage of an in-order, single-issue pipeline that has a floating-point extension. Each cycle it looks at one decoded instruction: its class, one destination register and up to two source registers. It keeps a small countdown for every register that an instruction still in flight will write. It holds the instruction in decode until each operand it reads can be reached through forwarding. How long it holds depends on the producing class and on the consuming class together. Write-after-read and write-after-write pairs never hold an instruction.

Instructions arrive on a valid/ready stream. `in_ready` low is the interlock: the upstream decode register must keep its contents and `in_valid` until a cycle in which `in_ready` is high. The issue side has no back-pressure. Each accepted instruction appears on the `out_*` pins for one cycle, and a held cycle shows up there one cycle later as a bubble (`out_valid` low). Three counters report issued instructions, interlock cycles and empty branch delay slots, so that cycles per instruction can be measured.

Top module: `ilk_interlock`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every countdown and all three counters. After reset, `out_valid` is low and no instruction is held.
- R2: `in_class` codes: 0 empty delay slot, 1 integer ALU (writes int `in_dest`, reads int `in_src1` and `in_src2`), 2 branch (reads int `in_src1` and `in_src2`, writes nothing), 3 FP load (writes FP `in_dest`, reads int `in_src1` as base), 4 FP store (reads FP `in_src1` as data and int `in_src2` as base), 5 FP ALU (writes FP `in_dest`, reads FP `in_src1` and `in_src2`). Codes 6 and 7 act as an empty slot.
- R3: An FP ALU op that reads the result of the FP ALU op issued just before it is held 3 cycles.
- R4: An FP store whose data operand is the result of the FP ALU op issued just before it is held 2 cycles.
- R5: An FP ALU op that reads the result of the FP load issued just before it is held 1 cycle. An FP store that stores the result of the FP load issued just before it is not held.
- R6: A branch that reads the result of the integer ALU op issued just before it is held 1 cycle. Integer ALU ops, load bases and store bases that read an integer ALU result are not held.
- R7: Every cycle between a producer's issue and the consumer's arrival, whether an instruction issues in it or not, cuts the hold by one, down to zero.
- R8: Only true read-after-write on the same register of the same file holds an instruction. WAR and WAW pairs, FP register k against int register k, and int register 0 never hold.
- R9: While held, `in_ready` is low and `out_valid` is low in the following cycle. An accepted instruction of class 1 to 5 appears on `out_valid`/`out_class`/`out_dest`/`out_src1`/`out_src2` in the next cycle. An accepted empty slot gives `out_valid` low.
- R10: `issue_count` counts accepted instructions of classes 1 to 5. `stall_count` counts cycles in which `in_valid` is high and `in_ready` is low. `slot_count` counts accepted empty slots. Each counter is visible one cycle after the event.
- R11: A five-instruction loop body (load, FP add, store, pointer decrement, branch, then an empty slot) takes 10 cycles per iteration. Scheduled as load, decrement, FP add, branch, store in the slot, it takes 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction may issue this cycle (low = interlock) |
| in_class | input | 3 | Instruction class code (see R2) |
| in_dest | input | REG_W | Destination register index |
| in_src1 | input | REG_W | First source register index |
| in_src2 | input | REG_W | Second source register index |
| out_valid | output | 1 | An instruction issued in the previous cycle |
| out_class | output | 3 | Class of the issued instruction |
| out_dest | output | REG_W | Destination of the issued instruction |
| out_src1 | output | REG_W | First source of the issued instruction |
| out_src2 | output | REG_W | Second source of the issued instruction |
| issue_count | output | CNT_W | Issued instruction count |
| stall_count | output | CNT_W | Interlock cycle count |
| slot_count | output | CNT_W | Empty delay slot count |

## Verification
Two functions meet in one cycle when an instruction that reads and writes the same FP register is released from its hold. In that cycle the countdown it waited on expires and the same entry is reloaded with its own latency. The bench provokes this with three chained FP ALU ops on one register and expects the third to be held a full 3 cycles again, not the leftover of the first. A sweep over producer class, consumer class, operand slot and distance 0 to 4 compares each measured hold with the table value minus the distance, floored at zero. It also checks the issue-side bubble in every held cycle.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [2:0] {
    CLS_SLOT   = 3'd0,
    CLS_IALU   = 3'd1,
    CLS_BRANCH = 3'd2,
    CLS_FLOAD  = 3'd3,
    CLS_FSTORE = 3'd4,
    CLS_FALU   = 3'd5
  } op_class_e;

  // Operand roles of one decoded instruction
  typedef struct packed {
    logic wr_en;     // writes a destination
    logic wr_fp;     // destination is in the FP file
    logic rd1_en;
    logic rd1_fp;
    logic rd2_en;
    logic rd2_fp;
    logic discount;  // consumer sees results one cycle earlier
    logic is_slot;   // empty delay slot
  } op_role_t;

endpackage

// File: rtl/ilk_role_decode.sv
module ilk_role_decode
  import ilk_pkg::*;
(
  input  logic [2:0] cls,
  output op_role_t   role
);

  op_class_e cls_e;
  assign cls_e = op_class_e'(cls);

  always_comb begin
    role = '0;
    case (cls_e)
      CLS_IALU: begin
        role.wr_en    = 1'b1;
        role.rd1_en   = 1'b1;
        role.rd2_en   = 1'b1;
        role.discount = 1'b1;
      end
      CLS_BRANCH: begin
        // compared in decode: no discount
        role.rd1_en = 1'b1;
        role.rd2_en = 1'b1;
      end
      CLS_FLOAD: begin
        role.wr_en    = 1'b1;
        role.wr_fp    = 1'b1;
        role.rd1_en   = 1'b1;
        role.discount = 1'b1;
      end
      CLS_FSTORE: begin
        role.rd1_en   = 1'b1;
        role.rd1_fp   = 1'b1;
        role.rd2_en   = 1'b1;
        role.discount = 1'b1;
      end
      CLS_FALU: begin
        role.wr_en  = 1'b1;
        role.wr_fp  = 1'b1;
        role.rd1_en = 1'b1;
        role.rd1_fp = 1'b1;
        role.rd2_en = 1'b1;
        role.rd2_fp = 1'b1;
      end
      default: role.is_slot = 1'b1;
    endcase
  end

endmodule

// File: rtl/ilk_scoreboard.sv
module ilk_scoreboard #(
  parameter int REG_W    = 5,
  parameter int LAT_BITS = 2,
  parameter int DISCOUNT = 1,
  parameter bit PIN_ZERO = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_W-1:0]      wr_idx,
  input  logic [LAT_BITS-1:0]   wr_lat,
  input  logic [1:0]            rd_en,
  input  logic [1:0][REG_W-1:0] rd_idx,
  input  logic                  rd_disc,
  output logic [1:0]            rd_busy
);

  localparam int NREG = 1 << REG_W;
  localparam logic [LAT_BITS-1:0] DISC_V = LAT_BITS'(DISCOUNT);

  // cycles until the pending result reaches the forwarding network
  logic [LAT_BITS-1:0] remain [NREG];

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++) begin
      if (rst || (PIN_ZERO && r == 0)) begin
        remain[r] <= '0;
      end else if (wr_en && wr_idx == REG_W'(r)) begin
        remain[r] <= wr_lat;
      end else if (remain[r] != '0) begin
        remain[r] <= remain[r] - 1'b1;
      end
    end
  end

  logic [LAT_BITS-1:0] thresh;
  assign thresh = rd_disc ? DISC_V : '0;

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [LAT_BITS-1:0] seen;
    assign seen       = remain[rd_idx[p]];
    assign rd_busy[p] = rd_en[p] && (seen > thresh);
  end

endmodule

// File: rtl/ilk_stats.sv
module ilk_stats #(
  parameter int NUM   = 3,
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM-1:0]            bump,
  output logic [NUM-1:0][CNT_W-1:0] tally
);

  always_ff @(posedge clk) begin
    for (int k = 0; k < NUM; k++) begin
      if (rst) begin
        tally[k] <= '0;
      end else if (bump[k]) begin
        tally[k] <= tally[k] + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ilk_interlock.sv
module ilk_interlock
  import ilk_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter int CNT_W     = 16,
  parameter int LAT_FALU  = 3,
  parameter int LAT_FLOAD = 1,
  parameter int LAT_IALU  = 1,
  parameter int DISCOUNT  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_class,
  input  logic [REG_W-1:0] in_dest,
  input  logic [REG_W-1:0] in_src1,
  input  logic [REG_W-1:0] in_src2,
  output logic             out_valid,
  output logic [2:0]       out_class,
  output logic [REG_W-1:0] out_dest,
  output logic [REG_W-1:0] out_src1,
  output logic [REG_W-1:0] out_src2,
  output logic [CNT_W-1:0] issue_count,
  output logic [CNT_W-1:0] stall_count,
  output logic [CNT_W-1:0] slot_count
);

  localparam int MAX_A    = (LAT_FALU > LAT_FLOAD) ? LAT_FALU : LAT_FLOAD;
  localparam int MAX_LAT  = (MAX_A > LAT_IALU) ? MAX_A : LAT_IALU;
  localparam int LAT_BITS = $clog2(MAX_LAT + 1);

  op_role_t role;
  ilk_role_decode u_dec (.cls(in_class), .role(role));

  logic [LAT_BITS-1:0] load_lat;
  always_comb begin
    case (in_class)
      CLS_FALU:  load_lat = LAT_BITS'(LAT_FALU);
      CLS_FLOAD: load_lat = LAT_BITS'(LAT_FLOAD);
      CLS_IALU:  load_lat = LAT_BITS'(LAT_IALU);
      default:   load_lat = '0;
    endcase
  end

  logic hazard, fire;
  logic [1:0] fp_rd_en, int_rd_en, fp_busy, int_busy;
  logic [1:0][REG_W-1:0] rd_idx;

  assign rd_idx    = {in_src2, in_src1};
  assign fp_rd_en  = {role.rd2_en &  role.rd2_fp, role.rd1_en &  role.rd1_fp};
  assign int_rd_en = {role.rd2_en & ~role.rd2_fp, role.rd1_en & ~role.rd1_fp};

  ilk_scoreboard #(
    .REG_W(REG_W), .LAT_BITS(LAT_BITS), .DISCOUNT(DISCOUNT), .PIN_ZERO(1'b0)
  ) u_fp_sb (
    .clk(clk), .rst(rst),
    .wr_en(fire & role.wr_en & role.wr_fp), .wr_idx(in_dest), .wr_lat(load_lat),
    .rd_en(fp_rd_en), .rd_idx(rd_idx), .rd_disc(role.discount),
    .rd_busy(fp_busy)
  );

  ilk_scoreboard #(
    .REG_W(REG_W), .LAT_BITS(LAT_BITS), .DISCOUNT(DISCOUNT), .PIN_ZERO(1'b1)
  ) u_int_sb (
    .clk(clk), .rst(rst),
    .wr_en(fire & role.wr_en & ~role.wr_fp), .wr_idx(in_dest), .wr_lat(load_lat),
    .rd_en(int_rd_en), .rd_idx(rd_idx), .rd_disc(role.discount),
    .rd_busy(int_busy)
  );

  assign hazard   = (|fp_busy) | (|int_busy);
  assign in_ready = ~hazard;
  assign fire     = in_valid & ~hazard;

  // issue register: a held cycle becomes a bubble
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_class <= '0;
      out_dest  <= '0;
      out_src1  <= '0;
      out_src2  <= '0;
    end else begin
      out_valid <= fire & ~role.is_slot;
      if (fire) begin
        out_class <= in_class;
        out_dest  <= in_dest;
        out_src1  <= in_src1;
        out_src2  <= in_src2;
      end
    end
  end

  logic [2:0][CNT_W-1:0] tally;
  ilk_stats #(.NUM(3), .CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst(rst),
    .bump({fire & role.is_slot, in_valid & hazard, fire & ~role.is_slot}),
    .tally(tally)
  );

  assign issue_count = tally[0];
  assign stall_count = tally[1];
  assign slot_count  = tally[2];

endmodule

// File: rtl/ilk_interlock_chk.sv
module ilk_interlock_chk #(
  parameter int REG_W = 5,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_class,
  input logic [REG_W-1:0] in_dest,
  input logic [REG_W-1:0] in_src1,
  input logic             out_valid,
  input logic [REG_W-1:0] out_dest,
  input logic [CNT_W-1:0] issue_count,
  input logic [CNT_W-1:0] stall_count,
  input logic [CNT_W-1:0] slot_count
);

  logic real_op;
  assign real_op = (in_class >= 3'd1) && (in_class <= 3'd5);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_valid && issue_count == '0 && stall_count == '0 && slot_count == '0)); // R1

  AST_FALU_CHAIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_class == 3'd5) |=>
    (!(in_valid && in_class == 3'd5 && in_src1 == $past(in_dest)) || !in_ready)); // R3

  AST_BRANCH_AFTER_IALU_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_class == 3'd1 && in_dest != '0) |=>
    (!(in_valid && in_class == 3'd2 && in_src1 == $past(in_dest)) || !in_ready)); // R6

  AST_HOLD_GIVES_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> !out_valid); // R9

  AST_ISSUE_PASSES: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && real_op) |=> (out_valid && out_dest == $past(in_dest))); // R9

  AST_STALL_TALLY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> stall_count == CNT_W'($past(stall_count) + 1'b1)); // R10

  AST_ISSUE_TALLY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && real_op) |=> issue_count == CNT_W'($past(issue_count) + 1'b1)); // R10

  AST_SLOT_TALLY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !real_op) |=>
    (slot_count == CNT_W'($past(slot_count) + 1'b1) && !out_valid)); // R10

endmodule

bind ilk_interlock ilk_interlock_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_class(in_class), .in_dest(in_dest), .in_src1(in_src1),
  .out_valid(out_valid), .out_dest(out_dest),
  .issue_count(issue_count), .stall_count(stall_count), .slot_count(slot_count)
);

// File: tb/test_ilk_interlock.sv
`timescale 1ns/1ps
module test_ilk_interlock;

  localparam int REG_W = 5;
  localparam int CNT_W = 16;

  localparam int C_SLOT = 0, C_IALU = 1, C_BR = 2, C_FLD = 3, C_FST = 4, C_FALU = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_class = '0;
  logic [REG_W-1:0] in_dest = '0, in_src1 = '0, in_src2 = '0;
  logic out_valid;
  logic [2:0] out_class;
  logic [REG_W-1:0] out_dest, out_src1, out_src2;
  logic [CNT_W-1:0] issue_count, stall_count, slot_count;

  always #2.5 clk = ~clk;  // 200 MHz

  ilk_interlock #(.REG_W(REG_W), .CNT_W(CNT_W)) i_ilk_interlock (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_dest(in_dest), .in_src1(in_src1), .in_src2(in_src2),
    .out_valid(out_valid), .out_class(out_class), .out_dest(out_dest),
    .out_src1(out_src1), .out_src2(out_src2),
    .issue_count(issue_count), .stall_count(stall_count), .slot_count(slot_count)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  bit exp_valid = 1'b0;
  int exp_class, exp_dest, exp_s1, exp_s2;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic check_out();
    if (exp_valid) begin
      check(out_valid == 1'b1, "R9", "out_valid after issue", int'(out_valid), 1);
      check(int'(out_class) == exp_class && int'(out_dest) == exp_dest &&
            int'(out_src1) == exp_s1 && int'(out_src2) == exp_s2,
            "R9", "issued fields (dest)", int'(out_dest), exp_dest);
    end else begin
      check(out_valid == 1'b0, "R9", "out_valid with nothing issued", int'(out_valid), 0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_valid = 1'b0;
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(issue_count == 0 && stall_count == 0 && slot_count == 0, "R1",
          "counters after reset", int'(issue_count + stall_count + slot_count), 0);
  endtask

  // present one instruction, return the number of held cycles
  task automatic issue(input int cls, input int dst, input int s1, input int s2,
                       output int nstall);
    @(negedge clk);
    check_out();
    in_valid = 1'b1;
    in_class = 3'(cls);
    in_dest  = REG_W'(dst);
    in_src1  = REG_W'(s1);
    in_src2  = REG_W'(s2);
    #0.5;
    nstall = 0;
    while (!in_ready) begin
      nstall++;
      @(negedge clk);
      check(out_valid == 1'b0, "R9", "bubble during hold", int'(out_valid), 0);
      #0.5;
    end
    exp_valid = (cls >= 1 && cls <= 5);
    exp_class = cls;
    exp_dest  = dst;
    exp_s1    = s1;
    exp_s2    = s2;
  endtask

  task automatic go_idle();
    @(negedge clk);
    check_out();
    in_valid = 1'b0;
    exp_valid = 1'b0;
  endtask

  // file of the producer's destination: 1 = FP
  function automatic int dest_fp(input int p);
    return (p == C_FALU || p == C_FLD) ? 1 : 0;
  endfunction

  // file of a consumer operand slot: 1 = FP, 0 = int, -1 = unused
  function automatic int src_file(input int c, input int slot);
    case (c)
      C_FALU: return 1;
      C_FST:  return (slot == 1) ? 1 : 0;
      C_FLD:  return (slot == 1) ? 0 : -1;
      default: return 0;
    endcase
  endfunction

  // hold for an adjacent producer/consumer pair (R3..R6)
  function automatic int pair_gap(input int p, input int c, input int slot);
    if (src_file(c, slot) != dest_fp(p)) return 0;
    if (p == C_FALU && c == C_FALU) return 3;
    if (p == C_FALU && c == C_FST && slot == 1) return 2;
    if (p == C_FLD && c == C_FALU) return 1;
    if (p == C_IALU && c == C_BR) return 1;
    return 0;
  endfunction

  function automatic string req_of(input int p, input int c, input int d);
    if (d > 0) return "R7";
    if (p == C_FALU && c == C_FALU) return "R3";
    if (p == C_FALU && c == C_FST) return "R4";
    if (p == C_FLD) return "R5";
    if (p == C_IALU) return "R6";
    return "R8";
  endfunction

  task automatic run_loop(input bit sched, input int iters);
    int total, n;
    do_reset();
    total = 0;
    for (int it = 0; it < iters; it++) begin
      if (!sched) begin
        issue(C_FLD, 0, 1, 0, n);  total += 1 + n;   // load F0 <- [R1]
        issue(C_FALU, 4, 0, 2, n); total += 1 + n;   // F4 <- F0 + F2
        issue(C_FST, 0, 4, 1, n);  total += 1 + n;   // [R1] <- F4
        issue(C_IALU, 1, 1, 0, n); total += 1 + n;   // R1 <- R1 - 8
        issue(C_BR, 0, 1, 2, n);   total += 1 + n;   // R1 != R2
        issue(C_SLOT, 0, 0, 0, n); total += 1 + n;   // empty slot
      end else begin
        issue(C_FLD, 0, 1, 0, n);  total += 1 + n;
        issue(C_IALU, 1, 1, 0, n); total += 1 + n;
        issue(C_FALU, 4, 0, 2, n); total += 1 + n;
        issue(C_BR, 0, 1, 2, n);   total += 1 + n;
        issue(C_FST, 0, 4, 1, n);  total += 1 + n;   // store in the slot
      end
    end
    go_idle();
    check(total == (sched ? 6 : 10) * iters, "R11", "loop cycles", total,
          (sched ? 6 : 10) * iters);
    check(int'(issue_count) == 5 * iters, "R10", "issue_count", int'(issue_count), 5 * iters);
    check(int'(stall_count) == (sched ? 1 : 4) * iters, "R10", "stall_count",
          int'(stall_count), (sched ? 1 : 4) * iters);
    check(int'(slot_count) == (sched ? 0 : iters), "R10", "slot_count",
          int'(slot_count), (sched ? 0 : iters));
  endtask

  initial begin
    int n;
    int prods[3] = '{C_FALU, C_FLD, C_IALU};

    do_reset();
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    // R3..R8: sweep producer, consumer, operand slot and distance
    foreach (prods[pi]) begin
      for (int c = 1; c <= 5; c++) begin
        for (int slot = 1; slot <= 2; slot++) begin
          if (src_file(c, slot) < 0) continue;
          for (int d = 0; d <= 4; d++) begin
            int p, expv, s1, s2;
            p = prods[pi];
            do_reset();
            issue(p, 5, 0, 0, n);
            for (int f = 0; f < d; f++) issue(C_IALU, 20, 0, 0, n);  // independent filler
            s1 = (slot == 1) ? 5 : 0;
            s2 = (slot == 2) ? 5 : 0;
            issue(c, 6, s1, s2, n);
            expv = pair_gap(p, c, slot) - d;
            if (expv < 0) expv = 0;
            check(n == expv, req_of(p, c, d), "hold cycles", n, expv);
          end
        end
      end
    end

    // R7: an idle cycle also counts toward the distance
    do_reset();
    issue(C_FALU, 5, 1, 2, n);
    go_idle();
    issue(C_FALU, 6, 5, 2, n);
    check(n == 2, "R7", "hold after one idle cycle", n, 2);

    // R8: WAR on F8, WAW on F5, int register 0
    do_reset();
    issue(C_FALU, 7, 8, 9, n);
    issue(C_FLD, 8, 0, 0, n);
    check(n == 0, "R8", "WAR hold", n, 0);
    do_reset();
    issue(C_FALU, 5, 1, 2, n);
    issue(C_FLD, 5, 0, 0, n);
    check(n == 0, "R8", "WAW hold", n, 0);
    do_reset();
    issue(C_IALU, 0, 1, 2, n);
    issue(C_BR, 0, 0, 0, n);
    check(n == 0, "R8", "int register 0 never busy", n, 0);

    // R3: self-dependent op reloads the entry it was released from
    do_reset();
    issue(C_FALU, 5, 1, 2, n);
    issue(C_FALU, 5, 5, 2, n);
    check(n == 3, "R3", "self-dependent hold", n, 3);
    issue(C_FALU, 6, 5, 2, n);
    check(n == 3, "R3", "hold after reload", n, 3);
    go_idle();
    check(int'(stall_count) == 6, "R10", "stall_count after chain", int'(stall_count), 6);

    // R1: reset wipes a pending countdown
    do_reset();
    issue(C_FALU, 5, 1, 2, n);
    do_reset();
    issue(C_FALU, 6, 5, 2, n);
    check(n == 0, "R1", "hold after reset", n, 0);

    // R11 / R10: loop bodies
    run_loop(1'b0, 3);
    run_loop(1'b1, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule